// File: doc/BRIEF.md
# Dual-Source Interrupt Down-Counter

This block raises a level interrupt after a programmed number of events. An 8-bit down-counter is stepped either by a qualified per-line pulse from the video side or by CPU cycles divided by four. A mode bit chooses which one drives it. Software uses four decoded write strobes that share one data byte. It sets a reload value, arms the counter, and enables or acknowledges the interrupt.

An arm write sets a sticky reload flag. While that flag is set, a reload-value write, an enable write and an acknowledge write each copy the reload value into the counter. In line mode, every line pulse clears the flag. An interrupt taken in line mode sets it again. The caller decodes the address and masks out the post-render line before it reaches `line_pulse`. At most one write strobe is active in any cycle.

Top module: `irq_downcounter`

## Requirements
- R1: Reset clears the counter, reload value, enable, mode, reload flag and prescaler, and drives `irq` low. After reset the block counts lines from zero.
- R2: A `wr_latch` strobe stores `wr_data` as the reload value. If the reload flag is set, it also loads `wr_data` into the counter.
- R3: A `wr_arm` strobe sets the reload flag, loads the counter from the reload value, and sets the mode from `wr_data[0]`: 1 selects CPU-cycle counting and 0 selects line counting.
- R4: A `wr_ack` strobe clears the enable and drops `irq`. If the reload flag is set, it also reloads the counter.
- R5: A `wr_en` strobe sets the enable. If the reload flag is set, it also reloads the counter.
- R6: In line mode, each `line_pulse` clears the reload flag and decrements the counter. A step from 0x00 to 0xFF while enabled raises `irq` and sets the reload flag again.
- R7: In cycle mode, a 2-bit prescaler advances on each `cpu_ce`. The counter decrements on every `cpu_ce` that finds the prescaler at 3. A wrap to 0xFF while enabled raises `irq`. A mode change does not clear the prescaler.
- R8: `line_pulse` has no effect in cycle mode, and `cpu_ce` has no effect in line mode.
- R9: `irq` stays high until a `wr_ack` or a reset. A wrap while disabled does not raise it.
- R10: Every effect appears after the next rising clock edge. If a counter load and a decrement fall in the same cycle, the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_latch | input | 1 | Reload-value write strobe |
| wr_arm | input | 1 | Arm and mode write strobe |
| wr_ack | input | 1 | Disable and acknowledge write strobe |
| wr_en | input | 1 | Enable write strobe |
| wr_data | input | 8 | Write data byte |
| line_pulse | input | 1 | One-cycle line event, already qualified |
| cpu_ce | input | 1 | CPU cycle enable |
| irq | output | 1 | Level interrupt request |

## Verification
Every strobe and event is registered once. Its effect on `irq` therefore shows one rising edge after the cycle in which the strobe or event was held. The bench drives each strobe or event for one cycle from a falling edge. It reads `irq` at the following falling edge, after exactly one rising edge. The counter has no port of its own, so counts are checked by timing. The bench counts events up to the one that should make the wrap, and checks that `irq` stays low before that event and goes high on it.

// File: rtl/irq_downcounter.sv
module irq_downcounter #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_latch,
  input  logic             wr_arm,
  input  logic             wr_ack,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             line_pulse,
  input  logic             cpu_ce,
  output logic             irq
);
  logic [CNT_W-1:0] latch_q, count_q;
  logic [PRE_W-1:0] pre_q;
  logic en_q, cyc_mode_q, reload_q, irq_q;

  wire line_tick = line_pulse & ~cyc_mode_q;
  wire cyc_tick  = cpu_ce & cyc_mode_q & (&pre_q);
  wire tick      = line_tick | cyc_tick;
  wire fire      = tick & (count_q == '0) & en_q;
  wire reload    = wr_arm | (reload_q & (wr_latch | wr_ack | wr_en));
  wire [CNT_W-1:0] load_val = wr_latch ? wr_data : latch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q    <= '0;
      count_q    <= '0;
      pre_q      <= '0;
      en_q       <= 1'b0;
      cyc_mode_q <= 1'b0;
      reload_q   <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      if (wr_latch) latch_q <= wr_data;
      if (wr_arm) cyc_mode_q <= wr_data[0];
      if (cpu_ce && cyc_mode_q) pre_q <= pre_q + 1'b1;

      if (reload)    count_q <= load_val;
      else if (tick) count_q <= count_q - 1'b1;

      if (wr_arm)         reload_q <= 1'b1;
      else if (line_tick) reload_q <= fire;

      if (wr_ack)     en_q <= 1'b0;
      else if (wr_en) en_q <= 1'b1;

      if (wr_ack)    irq_q <= 1'b0;
      else if (fire) irq_q <= 1'b1;
    end
  end

  assign irq = irq_q;
endmodule

module irq_downcounter_chk #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_latch,
  input logic             wr_arm,
  input logic             wr_ack,
  input logic [CNT_W-1:0] wr_data,
  input logic             irq,
  input logic             en_q,
  input logic             reload_q,
  input logic             cyc_mode_q,
  input logic [CNT_W-1:0] latch_q,
  input logic [CNT_W-1:0] count_q,
  input logic [PRE_W-1:0] pre_q
);
  a_r2_latch_reload: assert property (@(posedge clk) disable iff (rst)
    wr_latch && reload_q |=> count_q == $past(wr_data));
  a_r3_arm_load: assert property (@(posedge clk) disable iff (rst)
    wr_arm |=> reload_q && count_q == $past(latch_q) && cyc_mode_q == $past(wr_data[0]));
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (rst)
    wr_ack |=> !irq && !en_q);
  a_r9_irq_holds: assert property (@(posedge clk) disable iff (rst)
    irq && !wr_ack |=> irq);
  a_r9_rise_needs_enable: assert property (@(posedge clk) disable iff (rst)
    !irq ##1 irq |-> $past(en_q));
  a_r8_prescaler_idle: assert property (@(posedge clk) disable iff (rst)
    !cyc_mode_q |=> pre_q == $past(pre_q));
endmodule

bind irq_downcounter irq_downcounter_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst(rst), .wr_latch(wr_latch), .wr_arm(wr_arm), .wr_ack(wr_ack),
  .wr_data(wr_data), .irq(irq), .en_q(en_q), .reload_q(reload_q),
  .cyc_mode_q(cyc_mode_q), .latch_q(latch_q), .count_q(count_q), .pre_q(pre_q)
);

// File: tb/sim_irq_downcounter.sv
`timescale 1ns/1ps
module sim_irq_downcounter;
  logic clk = 1'b0, rst = 1'b1;
  logic wr_latch = 0, wr_arm = 0, wr_ack = 0, wr_en = 0;
  logic [7:0] wr_data = '0;
  logic line_pulse = 0, cpu_ce = 0;
  logic irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  irq_downcounter u0 (.clk(clk), .rst(rst), .wr_latch(wr_latch), .wr_arm(wr_arm),
    .wr_ack(wr_ack), .wr_en(wr_en), .wr_data(wr_data), .line_pulse(line_pulse),
    .cpu_ce(cpu_ce), .irq(irq));

  task automatic check(input logic exp, input string tag);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s: irq=%b expected %b", tag, irq, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; @(negedge clk); @(negedge clk); rst = 0;
  endtask

  // kind: 0 latch, 1 arm, 2 ack, 3 enable
  task automatic wr(input int kind, input logic [7:0] d);
    @(negedge clk);
    wr_data = d;
    wr_latch = (kind == 0); wr_arm = (kind == 1); wr_ack = (kind == 2); wr_en = (kind == 3);
    @(negedge clk);
    {wr_latch, wr_arm, wr_ack, wr_en} = '0;
  endtask

  task automatic lines(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); line_pulse = 1; @(negedge clk); line_pulse = 0;
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cpu_ce = 1; @(negedge clk); cpu_ce = 0;
    end
  endtask

  task automatic t_reset();
    do_reset();
    check(1'b0, "R1 irq low after reset");
    wr(3, 8'h00);
    lines(1);
    check(1'b1, "R1 zeroed counter in line mode wraps on first pulse");
    wr(2, 8'h00);
  endtask

  task automatic t_lines();
    do_reset();
    wr(0, 8'd3); wr(1, 8'h00); wr(3, 8'h00);
    for (int i = 0; i < 3; i++) begin lines(1); check(1'b0, "R6 before wrap"); end
    lines(1);
    check(1'b1, "R6 wrap raises irq");
    repeat (5) @(negedge clk);
    check(1'b1, "R9 irq held");
    wr(2, 8'h00);
    check(1'b0, "R4 ack drops irq");
    wr(3, 8'h00);
    lines(3);
    check(1'b0, "R5 enable reload, before wrap");
    lines(1);
    check(1'b1, "R5 enable reload, wrap");
  endtask

  task automatic t_flag();
    do_reset();
    wr(0, 8'd5); wr(1, 8'h00); wr(3, 8'h00); wr(0, 8'd1);
    lines(1);
    check(1'b0, "R2 latch reload with flag set, count 0");
    lines(1);
    check(1'b1, "R2 latch reload with flag set, wrap");
    do_reset();
    wr(0, 8'd3); wr(1, 8'h00); wr(3, 8'h00);
    lines(1);
    wr(0, 8'd0);
    lines(2);
    check(1'b0, "R6 flag cleared, latch write did not reload");
    lines(1);
    check(1'b1, "R6 flag cleared, wrap on fourth pulse");
  endtask

  task automatic t_disabled();
    do_reset();
    wr(0, 8'd1); wr(1, 8'h00);
    lines(2);
    check(1'b0, "R9 wrap while disabled");
  endtask

  task automatic t_cycle();
    do_reset();
    wr(0, 8'd1); wr(1, 8'h01); wr(3, 8'h00);
    lines(6);
    check(1'b0, "R8 line pulses ignored in cycle mode");
    cycles(7);
    check(1'b0, "R7 seven cycles no wrap");
    cycles(1);
    check(1'b1, "R7 eighth cycle wraps");
  endtask

  task automatic t_cpu_ignored();
    do_reset();
    wr(0, 8'd1); wr(1, 8'h00); wr(3, 8'h00);
    cycles(20);
    check(1'b0, "R8 cpu cycles ignored in line mode");
    lines(1);
    check(1'b0, "R8 first pulse");
    lines(1);
    check(1'b1, "R8 count intact, wrap on second pulse");
  endtask

  task automatic t_prescaler_kept();
    do_reset();
    wr(0, 8'd0); wr(1, 8'h01); wr(3, 8'h00);
    cycles(2);
    wr(1, 8'h00);
    cycles(5);
    wr(1, 8'h01);
    cycles(1);
    check(1'b0, "R7 prescaler kept, one cycle");
    cycles(1);
    check(1'b1, "R7 prescaler kept, wrap on second cycle");
  endtask

  task automatic t_same_cycle();
    do_reset();
    wr(0, 8'd2); wr(1, 8'h00); wr(3, 8'h00);
    lines(1);
    @(negedge clk); wr_data = 8'h00; wr_arm = 1; line_pulse = 1;
    @(negedge clk); wr_arm = 0; line_pulse = 0;
    lines(2);
    check(1'b0, "R10 load beats decrement, before wrap");
    lines(1);
    check(1'b1, "R10 load beats decrement, wrap");
  endtask

  initial begin
    t_reset();
    t_lines();
    t_flag();
    t_disabled();
    t_cycle();
    t_cpu_ignored();
    t_prescaler_kept();
    t_same_cycle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule